// File: doc/BRIEF.md
# Trigger Event Packet Formatter

This block turns each accepted trigger into a fixed ten-word record of 32-bit words, ready for a downstream network packet transmitter. When a trigger pulse arrives while packet output is enabled and no record is in flight, the block takes a one-cycle snapshot of the following inputs:

- the trigger timestamp;
- the accepted, input and pulser trigger counts;
- the sources of the trigger bitmap;
- the NIM and eSATA input bits, after masking.

It then streams the record out over a valid/ready word interface and flags the final word.

The record begins with a running packet number. A tagged header follows, then the seven data words, then a tagged footer. The header and the footer both carry the low 28 bits of the accepted-trigger count under a 4-bit tag, so a receiver can check that the two ends of the record belong together. A trigger that arrives while a record is still being sent is discarded. It is counted in a saturating drop counter and has no effect on the record in flight.

Top module: `trig_pkt_fmt`

## Requirements
- R1: After reset `out_valid` and `out_last` are 0, `drop_count` is 0, and the first record's word 0 is 0.
- R2: A `trig_in` pulse sampled with `cfg_trig_en[13]` = 1 while idle starts a record whose first word is presented in the next cycle. Word 0 is the packet number, which increments by one for each record started.
- R3: Word 1 is {4'h8, accepted count[27:0]} and word 9 is {4'h9, accepted count[27:0]}. `out_last` is 1 only while word 9 is presented.
- R4: Words 2 to 5 are, in order: the timestamp, the accepted count, the input count and the pulser count.
- R5: Word 6 is the trigger bitmap, with the following bit positions:
  - bit 0: `or16_in`
  - bit 1: `or32_in`
  - bit 2: `or_all_in`
  - bit 3: `esata_nim_or_in`
  - bit 4: `coinc_top_in`
  - bit 5: `coinc_bot_in`
  - bit 6: `coinc_in`
  - bit 7: always 0
  - bits 23:8: `coinc_reg_in`
  - bits 31:24: `mult_in[7:0]`
- R6: Word 7 is `nim_bits_in & nim_mask` and word 8 is `esata_bits_in & esata_mask` (2 bits per ADC, 16 ADCs).
- R7: A trigger sampled with `cfg_trig_en[13]` = 0 is ignored: no record is started, the drop count is unchanged, and the other enable bits have no effect.
- R8: All record fields are the values sampled in the trigger cycle. Later input changes do not alter the record.
- R9: An enabled trigger sampled while a record is in flight is discarded and increments `drop_count`. This includes the cycle in which word 9 is accepted. The count saturates at its maximum, and the record in flight is unchanged.
- R10: The word advances only in a cycle where `out_valid` and `out_ready` are both 1. While stalled, `out_valid` stays 1 and `out_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Accepted-trigger pulse |
| cfg_trig_en | input | 32 | Trigger-enable field; bit 13 enables record output |
| ts_in | input | 32 | Trigger timestamp |
| acc_cnt_in | input | 32 | Accepted-trigger count |
| in_cnt_in | input | 32 | Input-trigger count |
| pulser_cnt_in | input | 32 | Pulser-trigger count |
| or16_in | input | 1 | 16-channel ADC grand OR |
| or32_in | input | 1 | 32-channel ADC grand OR |
| or_all_in | input | 1 | Combined ADC OR |
| esata_nim_or_in | input | 1 | eSATA/NIM OR |
| coinc_top_in | input | 1 | Top coincidence |
| coinc_bot_in | input | 1 | Bottom coincidence |
| coinc_in | input | 1 | Coincidence |
| coinc_reg_in | input | 16 | Coincidence register |
| mult_in | input | 16 | Multiplicity value (low 8 bits used) |
| nim_bits_in | input | 32 | NIM input bits |
| nim_mask | input | 32 | NIM mask |
| esata_bits_in | input | 32 | eSATA input bits |
| esata_mask | input | 32 | eSATA mask |
| out_data | output | 32 | Record word |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Downstream ready |
| out_last | output | 1 | Final word of record |
| drop_count | output | DROP_W | Saturating count of discarded triggers |

## Verification
The bench goes after triggers that land on the cycle in which the footer is accepted, and triggers that land during long stalls. A design that frees itself one cycle early would start a new record there and never count the drop. Input counters are changed every cycle while a record is in flight, so a formatter that reads live values instead of a snapshot shows mismatched words. The bench drives a narrow drop counter past its limit so that a wrapping counter is caught. It also toggles the other enable bits while bit 13 is clear, which exposes an enable decoded from the wrong bit.

// File: rtl/trig_pkt_fmt.sv
module trig_pkt_fmt #(
  parameter int DROP_W = 16,
  parameter int CFG_W  = 32,
  parameter int EN_BIT = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic [CFG_W-1:0]  cfg_trig_en,
  input  logic [31:0]       ts_in,
  input  logic [31:0]       acc_cnt_in,
  input  logic [31:0]       in_cnt_in,
  input  logic [31:0]       pulser_cnt_in,
  input  logic              or16_in,
  input  logic              or32_in,
  input  logic              or_all_in,
  input  logic              esata_nim_or_in,
  input  logic              coinc_top_in,
  input  logic              coinc_bot_in,
  input  logic              coinc_in,
  input  logic [15:0]       coinc_reg_in,
  input  logic [15:0]       mult_in,
  input  logic [31:0]       nim_bits_in,
  input  logic [31:0]       nim_mask,
  input  logic [31:0]       esata_bits_in,
  input  logic [31:0]       esata_mask,
  output logic [31:0]       out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [DROP_W-1:0] drop_count
);
  localparam int NWORDS = 10;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);
  localparam logic [3:0] HDR_TAG = 4'h8;
  localparam logic [3:0] FTR_TAG = 4'h9;

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [31:0]      seq;
  logic [31:0]      s_seq, s_ts, s_acc, s_in, s_pul, s_map, s_nim, s_esa;

  wire        req   = trig_in && cfg_trig_en[EN_BIT];
  wire        start = req && !busy;
  wire        fire  = busy && out_ready;
  wire        done  = fire && (idx == LAST_IDX);
  wire [31:0] bitmap = {mult_in[7:0], coinc_reg_in, 1'b0, coinc_in, coinc_bot_in,
                        coinc_top_in, esata_nim_or_in, or_all_in, or32_in, or16_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      seq  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      seq  <= seq + 32'd1;
    end else if (fire) begin
      if (done) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      s_seq <= seq;
      s_ts  <= ts_in;
      s_acc <= acc_cnt_in;
      s_in  <= in_cnt_in;
      s_pul <= pulser_cnt_in;
      s_map <= bitmap;
      s_nim <= nim_bits_in & nim_mask;
      s_esa <= esata_bits_in & esata_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drop_count <= '0;
    else if (req && busy && drop_count != {DROP_W{1'b1}}) drop_count <= drop_count + 1'b1;
  end

  always_comb begin
    case (idx)
      4'd0:    out_data = s_seq;
      4'd1:    out_data = {HDR_TAG, s_acc[27:0]};
      4'd2:    out_data = s_ts;
      4'd3:    out_data = s_acc;
      4'd4:    out_data = s_in;
      4'd5:    out_data = s_pul;
      4'd6:    out_data = s_map;
      4'd7:    out_data = s_nim;
      4'd8:    out_data = s_esa;
      default: out_data = {FTR_TAG, s_acc[27:0]};
    endcase
  end

  assign out_valid = busy;
  assign out_last  = busy && (idx == LAST_IDX);

  assert_last_is_footer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_data[31:28] == FTR_TAG));
  assert_header_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx == IDX_W'(1)) |-> out_data[31:28] == HDR_TAG);
  assert_bitmap_bit7_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx == IDX_W'(6)) |-> !out_data[7]);
  assert_hold_while_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(idx)));
  assert_drop_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && out_valid && drop_count != {DROP_W{1'b1}}) |=> drop_count == $past(drop_count) + 1'b1);
  assert_disabled_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && !cfg_trig_en[EN_BIT] && !out_valid) |=> (!out_valid && $stable(drop_count)));
endmodule

// File: tb/tb_trig_pkt_fmt.sv
module tb_trig_pkt_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 3;
  localparam int WATCHDOG = 100000;

  logic clk = 0, rst_n = 0, trig_in = 0, out_ready = 0;
  logic [31:0] cfg_trig_en = 0, ts_in = 0, acc_cnt_in = 0, in_cnt_in = 0, pulser_cnt_in = 0;
  logic or16_in = 0, or32_in = 0, or_all_in = 0, esata_nim_or_in = 0;
  logic coinc_top_in = 0, coinc_bot_in = 0, coinc_in = 0;
  logic [15:0] coinc_reg_in = 0, mult_in = 0;
  logic [31:0] nim_bits_in = 0, nim_mask = 0, esata_bits_in = 0, esata_mask = 0;
  logic [31:0] out_data;
  logic out_valid, out_last;
  logic [DW-1:0] drop_count;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_q[$];
  int m_seq = 0, m_drop = 0;

  trig_pkt_fmt #(.DROP_W(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); m_seq = 0; m_drop = 0;
    end else begin
      automatic bit was_busy = exp_q.size() > 0;
      if (was_busy && out_ready) void'(exp_q.pop_front());
      if (trig_in && cfg_trig_en[13]) begin
        if (was_busy) begin
          if (m_drop < (1 << DW) - 1) m_drop++;
        end else begin
          exp_q.push_back(m_seq);
          exp_q.push_back({4'h8, acc_cnt_in[27:0]});
          exp_q.push_back(ts_in);
          exp_q.push_back(acc_cnt_in);
          exp_q.push_back(in_cnt_in);
          exp_q.push_back(pulser_cnt_in);
          exp_q.push_back({mult_in[7:0], coinc_reg_in, 1'b0, coinc_in, coinc_bot_in,
                           coinc_top_in, esata_nim_or_in, or_all_in, or32_in, or16_in});
          exp_q.push_back(nim_bits_in & nim_mask);
          exp_q.push_back(esata_bits_in & esata_mask);
          exp_q.push_back({4'h9, acc_cnt_in[27:0]});
          m_seq++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic string word_tag(int w);
    if (w == 0) return "R2 word0 seq";
    if (w == 1 || w == 9) return "R3 header/footer";
    if (w <= 5) return "R4 counters";
    if (w == 6) return "R5 bitmap";
    return "R6 masked bits";
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      automatic bit ev = exp_q.size() > 0;
      chk(out_valid == ev, "R10 out_valid", 32'(out_valid), 32'(ev));
      if (ev) begin
        chk(out_data == exp_q[0], word_tag(10 - exp_q.size()), out_data, exp_q[0]);
        chk(out_last == (exp_q.size() == 1), "R3 out_last", 32'(out_last), 32'(exp_q.size() == 1));
      end else
        chk(out_last == 1'b0, "R3 out_last idle", 32'(out_last), 0);
      chk(drop_count == DW'(m_drop), "R9 drop_count", 32'(drop_count), 32'(m_drop));
    end
  end

  task automatic randomize_inputs();
    ts_in = $urandom; acc_cnt_in = $urandom; in_cnt_in = $urandom; pulser_cnt_in = $urandom;
    {or16_in, or32_in, or_all_in, esata_nim_or_in, coinc_top_in, coinc_bot_in, coinc_in} = 7'($urandom);
    coinc_reg_in = 16'($urandom); mult_in = 16'($urandom);
    nim_bits_in = $urandom; nim_mask = $urandom; esata_bits_in = $urandom; esata_mask = $urandom;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(WATCHDOG * CLK_PERIOD);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_last && drop_count == 0, "R1 reset state",
        {out_valid, out_last, 30'(drop_count)}, 0);
    rst_n = 1;
    out_ready = 1;
    cfg_trig_en = 32'h2000;
    randomize_inputs();
    trig_in = 1;
    @(negedge clk); trig_in = 0;
    chk(out_valid && out_data == 0, "R1 first seq is 0", out_data, 0);
    repeat (12) @(negedge clk);
    chk(!out_valid, "R2 record completes", 32'(out_valid), 0);

    // R7: other enable bits set, bit 13 clear
    cfg_trig_en = 32'hFFFF_DFFF;
    trig_in = 1;
    @(negedge clk); trig_in = 0;
    chk(!out_valid, "R7 disabled trigger ignored", 32'(out_valid), 0);
    chk(drop_count == 0, "R7 drop unchanged", 32'(drop_count), 0);

    // R8/R10: trigger, stall, scramble inputs while in flight
    cfg_trig_en = 32'h2000;
    out_ready = 0;
    trig_in = 1;
    @(negedge clk); trig_in = 0;
    begin
      automatic logic [31:0] w0 = out_data;
      repeat (5) begin randomize_inputs(); @(negedge clk); end
      chk(out_valid && out_data == w0, "R10 stalled word held", out_data, w0);
    end
    out_ready = 1;
    repeat (12) @(negedge clk);

    // R9: footer-cycle trigger, then saturate the drop counter
    trig_in = 1;
    @(negedge clk); trig_in = 0;
    repeat (9) @(negedge clk);
    chk(out_last, "R9 footer presented", 32'(out_last), 1);
    trig_in = 1;
    @(negedge clk); trig_in = 0;
    chk(!out_valid && drop_count == 1, "R9 footer-cycle trigger dropped", 32'(drop_count), 1);
    trig_in = 1;
    repeat (12) @(negedge clk);
    trig_in = 0;
    chk(drop_count == DW'((1 << DW) - 1), "R9 drop saturates", 32'(drop_count), (1 << DW) - 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      trig_in = ($urandom % 6) == 0;
      out_ready = ($urandom % 3) != 0;
      cfg_trig_en = (($urandom % 8) == 0) ? 32'($urandom) & ~32'h2000 : 32'($urandom) | 32'h2000;
      @(negedge clk);
    end
    trig_in = 0; out_ready = 1;
    repeat (15) @(negedge clk);
    chk(!out_valid, "R2 drained", 32'(out_valid), 0);
    finish_run();
  end
endmodule